// File: doc/BRIEF.md
# Two-Stage 1:16 Serial-to-Parallel Demultiplexer

The block takes a single-bit serial stream, sampled on every rising edge of a fast serial clock, and gathers it into 16-bit parallel words. A parallel clock comes out with them, running at one sixteenth of the serial rate. The incoming bit is first retimed in a capture flop. The capture flop feeds four 4-bit lane shift registers. A first divide-by-four state machine picks which of the four registers takes each bit. A second divide-by-four state machine advances once per full turn of the first. Together they set the word boundary, the moment the 16-bit output register loads, and the shape of the parallel clock.

Both dividers are four-state machines with states PH_0, PH_1, PH_2 and PH_3. Each moves PH_0 to PH_1, PH_1 to PH_2, PH_2 to PH_3 and then wraps from PH_3 to PH_0. The first divider steps on every serial clock. The second steps only when the first wraps. Reset parks both dividers in PH_3, so both enter PH_0 on the first edge after reset. The output register loads when both dividers are in PH_0. The parallel clock falls on that same edge and rises when the first divider is in PH_0 and the second is in PH_2. No search for a frame or word pattern is made: the word boundary comes only from the moment reset is released. A downstream register samples the word on the rising edge of the parallel clock.

Top module: `deser16_twostage`

## Requirements
- R1: Each output word holds 16 consecutive serial bits with the first-received bit on pdata[15] (MSB) and the last-received bit on pdata[0] (LSB); received bit j of a word (j = 0..15) lands on pdata[15-j].
- R2: Edges are counted as edge 0, 1, 2, ... from the first rising sclk edge on which rst is low. Word w consists of the bits sampled on edges 16w to 16w+15.
- R3: Word w appears on pdata immediately after edge 16w+17, two serial clocks after its last bit was sampled.
- R4: Once loaded, a word stays unchanged on pdata for exactly 16 serial clocks.
- R5: pclk is low after edges m with (m mod 16) in 1..8 and high otherwise, giving a period of 16 serial clocks. pdata changes only on the edge where pclk falls.
- R6: rst is active high and synchronous. After any edge with rst high, pdata is 0 and pclk is 1. pdata stays 0 until the first word appears.
- R7: Asserting rst in the middle of a stream clears the output and restarts the word boundary, so that edge 0 becomes the first edge after the release. The data content never shifts the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bit clock; every flop updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sdata | input | 1 | Serial data, sampled on each rising sclk edge |
| pdata | output | 16 | Parallel word, MSB = first bit received |
| pclk | output | 1 | Parallel clock at sclk/16; falls when pdata updates |

## Verification
The bound checker keeps its own count of edges since reset. On every cycle it checks that pclk follows the 8-low/8-high pattern and that pdata moves only where pclk falls. It checks that reset leaves the outputs at 0 and 1. It also checks that the MSB and LSB of each new word match the serial bits sampled 18 and 3 edges earlier. The full lane order of all sixteen bits, output that stays zero before the first word, and realignment after a reset in mid-stream are shown only by the bench. It feeds a table of words, a counting pattern and a PRBS, and compares every output word against a model built from the requirements.

// File: rtl/deser16_pkg.sv
package deser16_pkg;

    // Number of lane shift registers and the length of each one.
    parameter int unsigned LANE_SR_NUM = 4;
    parameter int unsigned LANE_SR_LEN = 4;
    localparam int unsigned WORD_W     = LANE_SR_NUM * LANE_SR_LEN;

    // State of a divide-by-four stage.
    typedef enum logic [1:0] {
        PH_0 = 2'd0,
        PH_1 = 2'd1,
        PH_2 = 2'd2,
        PH_3 = 2'd3
    } quarter_e;

endpackage

// File: rtl/deser16_div4.sv
module deser16_div4
    import deser16_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     adv,
    output quarter_e phase,
    output logic     wrap
);

    quarter_e state_q;
    quarter_e state_d;

    // State register: reset parks in PH_3 so the first advance enters PH_0.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_3;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (adv) begin
            unique case (state_q)
                PH_0: state_d = PH_1;
                PH_1: state_d = PH_2;
                PH_2: state_d = PH_3;
                PH_3: state_d = PH_0;
            endcase
        end
    end

    assign phase = state_q;
    assign wrap  = adv && (state_q == PH_3);

endmodule

// File: rtl/deser16_lane_sr.sv
module deser16_lane_sr #(
    parameter int unsigned LEN = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en,
    input  logic           din,
    output logic [LEN-1:0] q
);

    // The oldest bit ends up in q[LEN-1]; new bits enter at q[0].
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (shift_en) begin
            q <= {q[LEN-2:0], din};
        end
    end

endmodule

// File: rtl/deser16_twostage.sv
module deser16_twostage
    import deser16_pkg::*;
(
    input  logic        sclk,
    input  logic        rst,
    input  logic        sdata,
    output logic [15:0] pdata,
    output logic        pclk
);

    logic                   cap_q;
    quarter_e               bit_ph;
    logic                   bit_wrap;
    quarter_e               word_ph;
    logic                   word_wrap;
    logic                   load;
    logic                   pclk_rise;
    logic [WORD_W-1:0]      word_d;
    logic [LANE_SR_LEN-1:0] lane_q [LANE_SR_NUM];

    // Input capture flop.
    always_ff @(posedge sclk) begin
        if (rst) begin
            cap_q <= 1'b0;
        end else begin
            cap_q <= sdata;
        end
    end

    // First divider: steps every serial clock and selects the lane register.
    deser16_div4 u_bit_div (
        .clk   (sclk),
        .rst   (rst),
        .adv   (1'b1),
        .phase (bit_ph),
        .wrap  (bit_wrap)
    );

    // Second divider: steps once per turn of the first.
    deser16_div4 u_word_div (
        .clk   (sclk),
        .rst   (rst),
        .adv   (bit_wrap),
        .phase (word_ph),
        .wrap  (word_wrap)
    );

    // Lane shift registers. Register r takes received bits r, r+N, r+2N, ...
    for (genvar r = 0; r < LANE_SR_NUM; r++) begin : g_lane
        deser16_lane_sr #(
            .LEN (LANE_SR_LEN)
        ) u_sr (
            .clk      (sclk),
            .rst      (rst),
            .shift_en (bit_ph == quarter_e'(2'(r))),
            .din      (cap_q),
            .q        (lane_q[r])
        );
        // Received bit j = r + N*i sits at lane_q[r][LEN-1-i] and goes to word bit 15-j.
        for (genvar i = 0; i < LANE_SR_LEN; i++) begin : g_bit
            assign word_d[WORD_W-1-r-LANE_SR_NUM*i] = lane_q[r][LANE_SR_LEN-1-i];
        end
    end

    assign load      = (bit_ph == PH_0) && (word_ph == PH_0);
    assign pclk_rise = (bit_ph == PH_0) && (word_ph == PH_2);

    // Output process: word register and parallel clock.
    always_ff @(posedge sclk) begin
        if (rst) begin
            pdata <= '0;
            pclk  <= 1'b1;
        end else if (load) begin
            pdata <= word_d;
            pclk  <= 1'b0;
        end else if (pclk_rise) begin
            pclk  <= 1'b1;
        end
    end

    // The second divider's wrap marks a word end; only its phase is needed here.
    logic unused_wrap;
    assign unused_wrap = word_wrap;

endmodule

// File: rtl/deser16_twostage_chk.sv
module deser16_twostage_chk (
    input logic        sclk,
    input logic        rst,
    input logic        sdata,
    input logic [15:0] pdata,
    input logic        pclk
);

    logic [3:0] cyc_q;
    logic [4:0] age_q;

    // Edge counters kept apart from the design's dividers.
    always_ff @(posedge sclk) begin
        if (rst) begin
            cyc_q <= 4'd0;
            age_q <= 5'd0;
        end else begin
            cyc_q <= cyc_q + 4'd1;
            if (age_q != 5'd31) begin
                age_q <= age_q + 5'd1;
            end
        end
    end

    // R5
    pclk_shape_chk: assert property (@(posedge sclk) disable iff (rst)
        pclk == !((cyc_q >= 4'd2) && (cyc_q <= 4'd9)));

    // R4
    pdata_hold_chk: assert property (@(posedge sclk) disable iff (rst)
        (!$past(rst) && !$stable(pdata)) |-> $fell(pclk));

    // R6
    reset_state_chk: assert property (@(posedge sclk) disable iff (rst)
        $past(rst) |-> (pdata == 16'h0000) && pclk);

    // R1
    lane_order_chk: assert property (@(posedge sclk) disable iff (rst)
        ((age_q >= 5'd18) && $fell(pclk)) |->
            (pdata[15] == $past(sdata, 18)) && (pdata[0] == $past(sdata, 3)));

endmodule

bind deser16_twostage deser16_twostage_chk u_chk (
    .sclk  (sclk),
    .rst   (rst),
    .sdata (sdata),
    .pdata (pdata),
    .pclk  (pclk)
);

// File: tb/tb_deser16_twostage.sv
module tb_deser16_twostage;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NTAB       = 8;
    localparam logic [15:0] TAB [NTAB] = '{
        16'h8000, 16'h0001, 16'hFFFF, 16'h0000,
        16'hA5C3, 16'h1234, 16'h7FFE, 16'hF00F
    };

    logic        sclk = 1'b0;
    logic        rst  = 1'b1;
    logic        sdata = 1'b0;
    logic [15:0] pdata;
    logic        pclk;

    int checks = 0;
    int fails  = 0;
    logic [15:0] words [16];

    deser16_twostage dut (
        .sclk  (sclk),
        .rst   (rst),
        .sdata (sdata),
        .pdata (pdata),
        .pclk  (pclk)
    );

    always #(CLK_PERIOD/2) sclk = ~sclk;

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Fill words[] for a pattern: 0 table, 1 counting, 2 PRBS.
    task automatic make_words(input int mode, input int nw);
        logic [15:0] lfsr = 16'hACE1;
        for (int w = 0; w < nw; w++) begin
            case (mode)
                0: words[w] = TAB[w % NTAB];
                1: words[w] = 16'(w * 16'h0111 + 16'h0F01);
                default: begin
                    for (int s = 0; s < 16; s++) begin
                        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    end
                    words[w] = lfsr;
                end
            endcase
        end
    endtask

    // Reset, then stream nw words MSB first and compare every cycle.
    task automatic run_stream(input int mode, input int nw);
        int total;
        make_words(mode, nw);
        @(negedge sclk);
        rst = 1'b1;
        @(negedge sclk);
        @(negedge sclk);
        // R6: reset state
        check16("R6 reset pdata", pdata, 16'h0000);
        check16("R6 reset pclk", {15'd0, pclk}, 16'h0001);
        rst = 1'b0;
        total = 16 * nw + 20;
        for (int n = 0; n < total; n++) begin
            int w;
            logic [15:0] exp_w;
            logic exp_clk;
            w = n / 16;
            sdata = (w < nw) ? words[w][15 - (n % 16)] : 1'b0;
            @(negedge sclk);
            // Now after edge n.
            exp_clk = !(((n % 16) >= 1) && ((n % 16) <= 8));
            check16("R5 pclk", {15'd0, pclk}, {15'd0, exp_clk});
            if (n < 17) begin
                check16("R6 pdata before first word", pdata, 16'h0000);
            end else begin
                w = (n - 17) / 16;
                exp_w = (w < nw) ? words[w] : 16'h0000;
                // R1 R2 R3 R4 R7: word content, boundary, latency and hold
                check16("R1 R3 R4 word", pdata, exp_w);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // Table walk: MSB/LSB single bits, all ones/zeros, mixed (R1, R2)
        run_stream(0, NTAB);
        // Counting pattern (R3, R4)
        run_stream(1, 12);
        // Mid-stream reset: feed 7 stray ones, then reset realigns (R7)
        for (int k = 0; k < 7; k++) begin
            @(negedge sclk);
            sdata = 1'b1;
        end
        run_stream(2, 10);
        // Reset asserted mid-word must clear the output on the next edge (R6, R7)
        make_words(1, 2);
        for (int k = 0; k < 21; k++) begin
            @(negedge sclk);
            sdata = 1'b1;
        end
        rst = 1'b1;
        @(negedge sclk);
        check16("R7 mid-stream reset pdata", pdata, 16'h0000);
        check16("R7 mid-stream reset pclk", {15'd0, pclk}, 16'h0001);
        // Ones-heavy PRBS after reset: boundary independent of data (R7)
        run_stream(2, 6);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule